// File: doc/BRIEF.md
# Power-Up Wiper Recall Sequencer

This block brings a bank of digitally controlled wiper registers out of reset in a fixed order. While it is held in reset, and for one cycle after reset is released, it drives every wiper load strobe with the mid-scale code 40h. In the same cycle it drives the access control register with its power-on value. It then waits until the supply-good flag says non-volatile reads can be trusted.

Once the supply is good, the block reads each wiper's stored start value from the non-volatile array, one wiper at a time and in ascending order, and loads that value into the matching wiper register. After the last load it raises a ready flag. The serial front end keeps this flag low as its gate, so any bus start condition seen earlier is discarded. If the supply flag drops before ready, the sequence starts again from mid-scale. After ready, a supply drop has no effect on the block.

State walk: RESET_MID goes to WAIT_SUPPLY unconditionally. WAIT_SUPPLY goes to READ_NV when supply is good. READ_NV goes to LOAD_WR. LOAD_WR goes back to READ_NV for the next wiper, or goes to READY after the last wiper. READ_NV and LOAD_WR both fall back to RESET_MID on supply loss. READY is terminal. With two wipers the visits run READ_NV/LOAD_WR for wiper 0, then for wiper 1.

Top module: `recall_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, every bit of `wr_load` is 1 and `wr_load_data` is 8'h40. In the same cycles `acr_load` is 1 and `acr_data` is 8'h40: bit 7 (volatile-select) is 0, bit 6 (run/not-shutdown) is 1 and the other bits are 0. `bus_ready` is 0.
- R2: The mid-scale state lasts exactly one cycle. After it, while `supply_ok` is 0, the block issues no read, no wiper strobe and no register-default strobe.
- R3: In the cycle after `supply_ok` is seen high in the waiting state, `nv_rd_en` is 1 and `nv_rd_addr` is 0.
- R4: The non-volatile array has one cycle of read latency. In the cycle after a read of address i, only bit i of `wr_load` is set, and `wr_load_data` equals `nv_rd_data` in that cycle.
- R5: Wipers are recalled in ascending order. Wiper i is read from address i, and the read of wiper i+1 follows directly after the load of wiper i.
- R6: `bus_ready` rises in the cycle after the last wiper load. With two wipers and `supply_ok` already high, that is six clock edges after reset is released.
- R7: If `supply_ok` is 0 during a read or load cycle, the next cycle is the mid-scale state (R1 strobes with 40h, `bus_ready` 0). Recall then restarts from address 0 once the supply returns.
- R8: Once `bus_ready` is 1 it stays 1. Later changes of `supply_ok` cause no read, no wiper strobe and no register-default strobe.
- R9: `nv_rd_en` and any `wr_load` bit are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| supply_ok | input | 1 | Supply is high enough for reliable non-volatile reads |
| nv_rd_en | output | 1 | Non-volatile read request |
| nv_rd_addr | output | 4 | Non-volatile read address |
| nv_rd_data | input | 8 | Read data, valid one cycle after the request |
| wr_load | output | 2 | Per-wiper load strobe |
| wr_load_data | output | 8 | Value to load into the strobed wipers |
| acr_load | output | 1 | Load strobe for the access control register default |
| acr_data | output | 8 | Access control register default value |
| bus_ready | output | 1 | Recall finished; serial interface may respond |

## Verification
The bench checks the exact cycle of each read and each load against the one-cycle memory latency. A design that loads in the read cycle, or two cycles late, would write stale or zero data into a wiper. It drops the supply in the middle of recall to prove that mid-scale is forced again and that recall restarts at wiper 0; a design that resumed at wiper 1 would leave wiper 0 holding 40h. It also toggles the supply after ready. A block that was not sticky would pull ready low again and reopen the bus gate.

// File: rtl/recall_pkg.sv
package recall_pkg;

    typedef enum logic [2:0] {
        ST_RESET_MID   = 3'd0,
        ST_WAIT_SUPPLY = 3'd1,
        ST_READ_NV     = 3'd2,
        ST_LOAD_WR     = 3'd3,
        ST_READY       = 3'd4
    } recall_state_t;

endpackage

// File: rtl/recall_fsm.sv
module recall_fsm
    import recall_pkg::*;
#(
    parameter int NUM_WIPERS = 2,
    parameter int IDX_W      = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    output recall_state_t    state,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WIPERS - 1);

    recall_state_t    state_nxt;
    logic [IDX_W-1:0] idx_nxt;

    // Next-state and wiper-index selection
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            ST_RESET_MID: begin
                state_nxt = ST_WAIT_SUPPLY;
                idx_nxt   = '0;
            end
            ST_WAIT_SUPPLY: begin
                idx_nxt = '0;
                if (supply_ok) state_nxt = ST_READ_NV;
            end
            ST_READ_NV: begin
                if (!supply_ok) state_nxt = ST_RESET_MID;
                else            state_nxt = ST_LOAD_WR;
            end
            ST_LOAD_WR: begin
                if (!supply_ok) begin
                    state_nxt = ST_RESET_MID;
                end else if (idx == LAST_IDX) begin
                    state_nxt = ST_READY;
                end else begin
                    state_nxt = ST_READ_NV;
                    idx_nxt   = idx + 1'b1;
                end
            end
            ST_READY: begin
                state_nxt = ST_READY;
            end
            default: begin
                state_nxt = ST_RESET_MID;
                idx_nxt   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RESET_MID;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    // R2: mid-scale lasts one cycle
    a_r2_mid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RESET_MID |=> state == ST_WAIT_SUPPLY);

    // R7: supply loss during recall returns to mid-scale
    a_r7_drop_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_READ_NV) || (state == ST_LOAD_WR)) && !supply_ok
        |=> state == ST_RESET_MID);

    // R8: READY is terminal
    a_r8_ready_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_READY |=> state == ST_READY);

endmodule

// File: rtl/recall_outputs.sv
module recall_outputs
    import recall_pkg::*;
#(
    parameter int              NUM_WIPERS  = 2,
    parameter int              IDX_W       = 1,
    parameter int              DATA_W      = 8,
    parameter int              NV_ADDR_W   = 4,
    parameter int              NV_BASE     = 0,
    parameter logic [DATA_W-1:0] MID_VALUE   = 8'h40,
    parameter logic [DATA_W-1:0] ACR_DEFAULT = 8'h40
) (
    input  recall_state_t        state,
    input  logic [IDX_W-1:0]     idx,
    input  logic [DATA_W-1:0]    nv_rd_data,
    output logic                 nv_rd_en,
    output logic [NV_ADDR_W-1:0] nv_rd_addr,
    output logic [NUM_WIPERS-1:0] wr_load,
    output logic [DATA_W-1:0]    wr_load_data,
    output logic                 acr_load,
    output logic [DATA_W-1:0]    acr_data,
    output logic                 bus_ready
);

    localparam logic [NV_ADDR_W-1:0] BASE_ADDR = NV_ADDR_W'(NV_BASE);

    logic in_mid;
    logic in_load;

    always_comb begin
        in_mid       = (state == ST_RESET_MID);
        in_load      = (state == ST_LOAD_WR);
        nv_rd_en     = (state == ST_READ_NV);
        nv_rd_addr   = BASE_ADDR + NV_ADDR_W'(idx);
        bus_ready    = (state == ST_READY);
        acr_load     = in_mid;
        acr_data     = in_mid ? ACR_DEFAULT : '0;
        if (in_mid)       wr_load_data = MID_VALUE;
        else if (in_load) wr_load_data = nv_rd_data;
        else              wr_load_data = '0;
    end

    for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_strobe
        assign wr_load[g] = in_mid || (in_load && (idx == IDX_W'(g)));
    end

endmodule

// File: rtl/recall_sequencer.sv
module recall_sequencer
    import recall_pkg::*;
#(
    parameter int NUM_WIPERS = 2,
    parameter int DATA_W     = 8,
    parameter int NV_ADDR_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  supply_ok,
    output logic                  nv_rd_en,
    output logic [NV_ADDR_W-1:0]  nv_rd_addr,
    input  logic [DATA_W-1:0]     nv_rd_data,
    output logic [NUM_WIPERS-1:0] wr_load,
    output logic [DATA_W-1:0]     wr_load_data,
    output logic                  acr_load,
    output logic [DATA_W-1:0]     acr_data,
    output logic                  bus_ready
);

    localparam int IDX_W = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;

    recall_state_t    state;
    logic [IDX_W-1:0] idx;

    recall_fsm #(
        .NUM_WIPERS(NUM_WIPERS),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .state    (state),
        .idx      (idx)
    );

    recall_outputs #(
        .NUM_WIPERS (NUM_WIPERS),
        .IDX_W      (IDX_W),
        .DATA_W     (DATA_W),
        .NV_ADDR_W  (NV_ADDR_W),
        .NV_BASE    (0),
        .MID_VALUE  (DATA_W'(8'h40)),
        .ACR_DEFAULT(DATA_W'(8'h40))
    ) u_out (
        .state       (state),
        .idx         (idx),
        .nv_rd_data  (nv_rd_data),
        .nv_rd_en    (nv_rd_en),
        .nv_rd_addr  (nv_rd_addr),
        .wr_load     (wr_load),
        .wr_load_data(wr_load_data),
        .acr_load    (acr_load),
        .acr_data    (acr_data),
        .bus_ready   (bus_ready)
    );

    // R4: a read with good supply is followed by exactly one wiper load of the read data
    a_r4_load_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        nv_rd_en && supply_ok |=> ($countones(wr_load) == 1) && (wr_load_data == nv_rd_data));

    // R9: read request and wiper strobe never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_rd_en && (|wr_load)));

    // R8: after ready the block is quiet and stays ready
    a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> bus_ready && !nv_rd_en && (wr_load == '0) && !acr_load);

    // R1: the default-register strobe only comes with the mid-scale strobe on all wipers
    a_r1_defaults_with_mid: assert property (@(posedge clk) disable iff (!rst_n)
        acr_load |-> (&wr_load) && !bus_ready);

endmodule

// File: tb/test_recall_sequencer.sv
module test_recall_sequencer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok;
    logic       nv_rd_en;
    logic [3:0] nv_rd_addr;
    logic [7:0] nv_rd_data;
    logic [1:0] wr_load;
    logic [7:0] wr_load_data;
    logic       acr_load;
    logic [7:0] acr_data;
    logic       bus_ready;

    logic [7:0] nv_mem [0:15];

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // One-cycle-latency non-volatile array model
    always @(posedge clk) begin
        if (nv_rd_en) nv_rd_data <= nv_mem[nv_rd_addr];
    end

    recall_sequencer i_recall_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .nv_rd_en    (nv_rd_en),
        .nv_rd_addr  (nv_rd_addr),
        .nv_rd_data  (nv_rd_data),
        .wr_load     (wr_load),
        .wr_load_data(wr_load_data),
        .acr_load    (acr_load),
        .acr_data    (acr_data),
        .bus_ready   (bus_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_quiet(input string req);
        check(!nv_rd_en, req, 32'(nv_rd_en), 0);
        check(wr_load == 2'b00, req, 32'(wr_load), 0);
        check(!acr_load, req, 32'(acr_load), 0);
    endtask

    task automatic check_mid(input string req);
        check(wr_load == 2'b11, req, 32'(wr_load), 32'h3);
        check(wr_load_data == 8'h40, req, 32'(wr_load_data), 32'h40);
        check(acr_load && acr_data == 8'h40, req, 32'(acr_data), 32'h40);
        check(!bus_ready, req, 32'(bus_ready), 0);
    endtask

    task automatic check_read(input int a, input string req);
        check(nv_rd_en, req, 32'(nv_rd_en), 1);
        check(nv_rd_addr == 4'(a), req, 32'(nv_rd_addr), 32'(a));
        check(wr_load == 2'b00, {req, " R9"}, 32'(wr_load), 0);
    endtask

    task automatic check_load(input int w, input string req);
        check(wr_load == 2'(1 << w), req, 32'(wr_load), 32'(1 << w));
        check(wr_load_data == nv_mem[w], req, 32'(wr_load_data), 32'(nv_mem[w]));
        check(!nv_rd_en, {req, " R9"}, 32'(nv_rd_en), 0);
    endtask

    // R1, R2: reset state, mid-scale for one cycle, quiet wait
    task automatic t_reset_and_wait();
        rst_n = 1'b0; supply_ok = 1'b0;
        tick(); tick();
        check_mid("R1 in reset");
        rst_n = 1'b1;
        tick();
        check_quiet("R2 wait after one mid cycle");
        check(!bus_ready, "R2 not ready", 32'(bus_ready), 0);
        for (int i = 0; i < 5; i++) begin
            tick();
            check_quiet("R2 wait holds");
        end
    endtask

    // R3..R6: full recall sequence with given stored values
    task automatic t_recall(input logic [7:0] v0, input logic [7:0] v1);
        nv_mem[0] = v0; nv_mem[1] = v1;
        rst_n = 1'b0; supply_ok = 1'b1;
        tick();
        check_mid("R1 reset with supply good");
        rst_n = 1'b1;
        tick();           // edge 1: wait
        check_quiet("R2 wait cycle");
        tick();           // edge 2: read 0
        check_read(0, "R3 first read");
        tick();           // edge 3: load 0
        check_load(0, "R4 load wiper0");
        tick();           // edge 4: read 1
        check_read(1, "R5 second read");
        tick();           // edge 5: load 1
        check_load(1, "R4 load wiper1");
        check(!bus_ready, "R6 not ready during last load", 32'(bus_ready), 0);
        tick();           // edge 6: ready
        check(bus_ready, "R6 ready after last load", 32'(bus_ready), 1);
        check_quiet("R8 quiet at ready");
    endtask

    // R7: supply loss mid-recall
    task automatic t_drop_midway();
        nv_mem[0] = 8'h2C; nv_mem[1] = 8'h51;
        rst_n = 1'b0; supply_ok = 1'b1;
        tick();
        rst_n = 1'b1;
        tick(); tick(); tick(); tick(); // now in read 1
        check_read(1, "R7 setup read1");
        supply_ok = 1'b0;
        tick();
        check_mid("R7 back to mid-scale");
        tick();
        check_quiet("R7 waiting after drop");
        supply_ok = 1'b1;
        tick();
        check_read(0, "R7 restart at address 0");
        tick();
        check_load(0, "R7 reload wiper0");
        tick();
        // drop during load-stage of wiper 1 path: first reach read1
        check_read(1, "R7 read1 again");
        tick();
        check_load(1, "R7 reload wiper1");
        supply_ok = 1'b0;
        tick();
        check_mid("R7 drop during last load");
        check(!bus_ready, "R7 no ready after drop", 32'(bus_ready), 0);
    endtask

    // R8: sticky ready
    task automatic t_ready_sticky();
        t_recall(8'h33, 8'h44);
        for (int i = 0; i < 6; i++) begin
            supply_ok = i[0];
            tick();
            check(bus_ready, "R8 ready sticky", 32'(bus_ready), 1);
            check_quiet("R8 supply change ignored");
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) nv_mem[i] = 8'(i * 3 + 1);
        rst_n = 1'b0;
        supply_ok = 1'b0;
        t_reset_and_wait();
        t_recall(8'h15, 8'h6A);
        t_recall(8'h7F, 8'h00);
        t_drop_midway();
        t_ready_sticky();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule